// File: doc/BRIEF.md
# Trap CSR Bank with Write Legalization

This block stores the machine-level and supervisor-level trap registers of a 64-bit RISC-V hart. The instruction pipeline hands it a 12-bit CSR address, a 64-bit write value and a write strobe. Every write is shaped by a rule that belongs to the target register before it lands in a flop. The read path is combinational: rdata follows the address in the same cycle and always shows the value held before any pending write.

The supervisor status register has no storage of its own. Reads and writes of it go through a fixed field mask onto the machine status register. The machine and supervisor trap-vector registers share a single mode-check rule, so a write with a reserved mode cannot install a mode that has no meaning. The supervisor exception delegation register keeps only its low nine bits. The scratch, exception-PC, cause and trap-value registers store the written value unchanged.

Top module: `csr_trap_bank`

## Requirements
- R1: While reset is held, and after it is released, every implemented register reads as zero. Assertion of rst_n clears the registers without waiting for a clock edge.
- R2: A write to 0x305 (machine trap vector) or 0x105 (supervisor trap vector) whose bits [1:0] are 0 (direct) or 1 (vectored) stores the full 64-bit value.
- R3: A trap-vector write whose bits [1:0] are 2 or 3 (reserved) stores bits [63:2] of the new value and keeps the register's previous bits [1:0].
- R4: A write to 0x100 (supervisor status view) changes only the machine status (0x300) bits in the status mask, which covers bit 0, bit 1, bit 4, bit 5, bit 8, bits 14:13, bits 16:15, bit 18, bit 19, bits 33:32 and bit 63 (mask 0x8000_0003_000D_E133). Every other bit keeps its old value.
- R5: A read of 0x100 returns the machine status register ANDed with the status mask. All other bits read as zero.
- R6: A write to 0x102 (supervisor exception delegation) stores bits [8:0] of the value and zeroes bits [63:9].
- R7: Writes to 0x300, 0x302, 0x340, 0x341, 0x140, 0x141, 0x142 and 0x143 store the full value. A read of the same address returns that value.
- R8: A read of any other address returns zero. A write to any other address changes no stored register.
- R9: A write takes effect at the rising clock edge while wr_en is high. In the cycle of the write, rdata still shows the old value. While wr_en is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 12 | CSR address for both read and write |
| wdata | input | 64 | Value to be legalized and written |
| rdata | output | 64 | Combinational read data for addr |

## Verification
The plain registers are written with alternating, all-ones and sparse patterns. These show that no bit is dropped or shifted on the way to storage. The trap vectors are given each mode value in turn: 0 and 1 must be stored as written, and 2 or 3 must arrive with the previous mode bits. Because the mode before each reserved write differs, a design that always forces direct mode gives a different result from one that keeps the old mode. The status alias is exercised from an all-zero and from an all-ones machine status, with all-ones and all-zero written through the view, so that mask bits and non-mask bits are checked in both directions. The delegation register gets all-ones, which separates a 9-bit truncation from any wider or narrower one. Writes to unmapped addresses are followed by reads of live registers, to show that nothing was disturbed.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

  localparam int XLEN   = 64;
  localparam int ADDR_W = 12;

  // Status field positions inside the machine status word
  localparam int ST_UIE  = 0;
  localparam int ST_SIE  = 1;
  localparam int ST_UPIE = 4;
  localparam int ST_SPIE = 5;
  localparam int ST_SPP  = 8;
  localparam int ST_FS   = 13;  // two bits
  localparam int ST_XS   = 15;  // two bits
  localparam int ST_SUM  = 18;
  localparam int ST_MXR  = 19;
  localparam int ST_UXL  = 32;  // two bits
  localparam int ST_SD   = XLEN - 1;

  // Width of the stored part of the supervisor exception delegation register
  localparam int SEDELEG_W = 9;

  // Trap-vector mode field
  localparam int TVEC_MODE_W = 2;

  // CSR addresses
  localparam logic [ADDR_W-1:0] A_SSTATUS  = 12'h100;
  localparam logic [ADDR_W-1:0] A_MSTATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] A_MEDELEG  = 12'h302;
  localparam logic [ADDR_W-1:0] A_MTVEC    = 12'h305;
  localparam logic [ADDR_W-1:0] A_MSCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] A_MEPC     = 12'h341;
  localparam logic [ADDR_W-1:0] A_STVEC    = 12'h105;
  localparam logic [ADDR_W-1:0] A_SEDELEG  = 12'h102;
  localparam logic [ADDR_W-1:0] A_SSCRATCH = 12'h140;
  localparam logic [ADDR_W-1:0] A_SEPC     = 12'h141;
  localparam logic [ADDR_W-1:0] A_SCAUSE   = 12'h142;
  localparam logic [ADDR_W-1:0] A_STVAL    = 12'h143;

  // Physical storage slots
  localparam int I_MSTATUS  = 0;
  localparam int I_MEDELEG  = 1;
  localparam int I_MTVEC    = 2;
  localparam int I_MSCRATCH = 3;
  localparam int I_MEPC     = 4;
  localparam int I_STVEC    = 5;
  localparam int I_SEDELEG  = 6;
  localparam int I_SSCRATCH = 7;
  localparam int I_SEPC     = 8;
  localparam int I_SCAUSE   = 9;
  localparam int I_STVAL    = 10;
  localparam int NREG       = 11;

  // Number of trap-vector registers sharing the mode rule
  localparam int NTVEC = 2;

  typedef enum logic [1:0] {
    TV_DIRECT   = 2'd0,
    TV_VECTORED = 2'd1,
    TV_RSVD2    = 2'd2,
    TV_RSVD3    = 2'd3
  } tvec_mode_e;

  function automatic logic [XLEN-1:0] build_status_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[ST_UIE]      = 1'b1;
    m[ST_SIE]      = 1'b1;
    m[ST_UPIE]     = 1'b1;
    m[ST_SPIE]     = 1'b1;
    m[ST_SPP]      = 1'b1;
    m[ST_FS +: 2]  = 2'b11;
    m[ST_XS +: 2]  = 2'b11;
    m[ST_SUM]      = 1'b1;
    m[ST_MXR]      = 1'b1;
    m[ST_UXL +: 2] = 2'b11;
    m[ST_SD]       = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] STATUS_MASK = build_status_mask();

  function automatic logic [ADDR_W-1:0] slot_addr(input int idx);
    case (idx)
      I_MSTATUS:  return A_MSTATUS;
      I_MEDELEG:  return A_MEDELEG;
      I_MTVEC:    return A_MTVEC;
      I_MSCRATCH: return A_MSCRATCH;
      I_MEPC:     return A_MEPC;
      I_STVEC:    return A_STVEC;
      I_SEDELEG:  return A_SEDELEG;
      I_SSCRATCH: return A_SSCRATCH;
      I_SEPC:     return A_SEPC;
      I_SCAUSE:   return A_SCAUSE;
      default:    return A_STVAL;
    endcase
  endfunction

  function automatic int tvec_slot(input int t);
    return (t == 0) ? I_MTVEC : I_STVEC;
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [NREG-1:0]   rd_sel,
  output logic [NREG-1:0]   wr_sel,
  output logic              view_hit,
  output logic              hit
);

  logic [NREG-1:0] direct_sel;

  assign view_hit = (addr == A_SSTATUS);

  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign direct_sel[g] = (addr == slot_addr(g));
  end

  // The status view reaches the machine status slot on writes only
  always_comb begin
    rd_sel = direct_sel;
    wr_sel = '0;
    for (int i = 0; i < NREG; i++) begin
      if (i == I_MSTATUS) begin
        wr_sel[i] = wr_en & (direct_sel[i] | view_hit);
      end else begin
        wr_sel[i] = wr_en & direct_sel[i];
      end
    end
  end

  assign hit = (|direct_sel) | view_hit;

  AST_WR_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R8

  AST_NO_WR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (wr_sel == '0)); // R9

endmodule

// File: rtl/csr_tvec_legal.sv
module csr_tvec_legal
  import csr_trap_pkg::*;
(
  input  logic [XLEN-1:0] old_q,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] nxt
);

  tvec_mode_e new_mode;
  logic       mode_ok;

  assign new_mode = tvec_mode_e'(wval[TVEC_MODE_W-1:0]);

  always_comb begin
    case (new_mode)
      TV_DIRECT, TV_VECTORED: mode_ok = 1'b1;
      default:                mode_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (mode_ok) begin
      nxt = wval;
    end else begin
      nxt = {wval[XLEN-1:TVEC_MODE_W], old_q[TVEC_MODE_W-1:0]};
    end
  end

endmodule

// File: rtl/csr_status_view.sv
module csr_status_view
  import csr_trap_pkg::*;
(
  input  logic [XLEN-1:0] mstatus_q,
  input  logic [XLEN-1:0] wval,
  output logic [XLEN-1:0] merged,
  output logic [XLEN-1:0] view
);

  always_comb begin
    merged = (mstatus_q & ~STATUS_MASK) | (wval & STATUS_MASK);
    view   = mstatus_q & STATUS_MASK;
  end

endmodule

// File: rtl/csr_trap_bank.sv
module csr_trap_bank
  import csr_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   rdata
);

  logic            rst_n_s;
  logic [NREG-1:0] rd_sel;
  logic [NREG-1:0] wr_sel;
  logic            view_hit;
  logic            hit;

  logic [XLEN-1:0] regs_q [NREG];
  logic [XLEN-1:0] legal  [NREG];
  logic [XLEN-1:0] tvec_nxt [NTVEC];
  logic [XLEN-1:0] st_merged;
  logic [XLEN-1:0] st_view;

  csr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  csr_addr_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_sel   (rd_sel),
    .wr_sel   (wr_sel),
    .view_hit (view_hit),
    .hit      (hit)
  );

  for (genvar t = 0; t < NTVEC; t++) begin : g_tvec
    csr_tvec_legal u_tv (
      .old_q (regs_q[tvec_slot(t)]),
      .wval  (wdata),
      .nxt   (tvec_nxt[t])
    );
  end

  csr_status_view u_sv (
    .mstatus_q (regs_q[I_MSTATUS]),
    .wval      (wdata),
    .merged    (st_merged),
    .view      (st_view)
  );

  // Next-state: per-slot legalization
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      if (i == I_MSTATUS) begin
        legal[i] = view_hit ? st_merged : wdata;
      end else if (i == I_MTVEC) begin
        legal[i] = tvec_nxt[0];
      end else if (i == I_STVEC) begin
        legal[i] = tvec_nxt[1];
      end else if (i == I_SEDELEG) begin
        legal[i] = XLEN'(wdata[SEDELEG_W-1:0]);
      end else begin
        legal[i] = wdata;
      end
    end
  end

  // Storage with explicit write enables
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) begin
        regs_q[g] <= '0;
      end else if (wr_sel[g]) begin
        regs_q[g] <= legal[g];
      end
    end
  end

  // Read path
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel[i]) begin
        rdata = rdata | regs_q[i];
      end
    end
    if (view_hit) begin
      rdata = st_view;
    end
  end

  AST_TVEC_DIRECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == A_MTVEC && !wdata[1]) |=> (regs_q[I_MTVEC] == $past(wdata))); // R2

  AST_TVEC_RSVD_MODE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == A_STVEC && wdata[1]) |=>
      (regs_q[I_STVEC][1:0] == $past(regs_q[I_STVEC][1:0]))); // R3

  AST_SSTATUS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == A_SSTATUS) |=>
      ((regs_q[I_MSTATUS] & ~STATUS_MASK) == $past(regs_q[I_MSTATUS] & ~STATUS_MASK))); // R4

  AST_SSTATUS_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    (addr == A_SSTATUS) |-> ((rdata & ~STATUS_MASK) == '0)); // R5

  AST_SEDELEG_UPPER: assert property (@(posedge clk) disable iff (!rst_n_s)
    regs_q[I_SEDELEG][XLEN-1:SEDELEG_W] == '0); // R6

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    !hit |-> (rdata == '0)); // R8

  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !hit) |=> (regs_q[I_MEPC] == $past(regs_q[I_MEPC]))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wr_en |=> (regs_q[I_MSCRATCH] == $past(regs_q[I_MSCRATCH]))); // R9

endmodule

// File: tb/sim_csr_trap_bank.sv
module sim_csr_trap_bank;

  localparam int  NV   = 15;
  localparam time TCLK = 4ns;
  localparam logic [63:0] MASK = 64'h8000_0003_000D_E133;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [63:0] wdata;
  logic [63:0] rdata;

  int n_cmp;
  int n_bad;
  bit done;

  csr_trap_bank u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  // Write, then read back the same address
  localparam logic [11:0] V_ADDR [NV] = '{
    12'h340, 12'h341, 12'h140, 12'h141, 12'h142, 12'h143, 12'h302, 12'h300,
    12'h305, 12'h305, 12'h105, 12'h105, 12'h102, 12'h102, 12'h100
  };
  localparam logic [63:0] V_WD [NV] = '{
    64'hA5A5_A5A5_A5A5_A5A5,  // R7
    64'h1234_5678_9ABC_DEF0,  // R7
    64'hFFFF_FFFF_FFFF_FFFF,  // R7
    64'h0000_0000_0000_0003,  // R7
    64'h8000_0000_0000_0005,  // R7
    64'hDEAD_BEEF_0000_0001,  // R7
    64'hFFFF_0000_FFFF_0000,  // R7
    64'h0000_0000_0000_0000,  // R7
    64'h0000_0000_8000_0001,  // R2 vectored
    64'h0000_0000_4000_0002,  // R3 reserved, old mode 1
    64'h0000_0000_0000_1000,  // R2 direct
    64'hFFFF_FFFF_FFFF_FFFF,  // R3 reserved, old mode 0
    64'hFFFF_FFFF_FFFF_FFFF,  // R6
    64'h0000_0000_0000_0100,  // R6
    64'hFFFF_FFFF_FFFF_FFFF   // R5
  };
  localparam logic [63:0] V_EXP [NV] = '{
    64'hA5A5_A5A5_A5A5_A5A5,
    64'h1234_5678_9ABC_DEF0,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0000_0000_0003,
    64'h8000_0000_0000_0005,
    64'hDEAD_BEEF_0000_0001,
    64'hFFFF_0000_FFFF_0000,
    64'h0000_0000_0000_0000,
    64'h0000_0000_8000_0001,
    64'h0000_0000_4000_0001,
    64'h0000_0000_0000_1000,
    64'hFFFF_FFFF_FFFF_FFFC,
    64'h0000_0000_0000_01FF,
    64'h0000_0000_0000_0100,
    64'h8000_0003_000D_E133
  };
  localparam int V_REQ [NV] = '{7, 7, 7, 7, 7, 7, 7, 7, 2, 3, 2, 3, 6, 6, 5};

  task automatic compare(input string tag, input logic [11:0] a,
                         input logic [63:0] exp);
    n_cmp++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [11:0] a,
                     input logic [63:0] exp);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    #1;
    compare(tag, a, exp);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    chk("R1", 12'h300, 64'h0);
    chk("R1", 12'h305, 64'h0);
    chk("R1", 12'h105, 64'h0);
    chk("R1", 12'h340, 64'h0);
    chk("R1", 12'h143, 64'h0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      do_write(V_ADDR[k], V_WD[k]);
      chk($sformatf("R%0d", V_REQ[k]), V_ADDR[k], V_EXP[k]);
    end

    // R4: the all-ones view write reached only the mask bits of a zero status
    chk("R4", 12'h300, MASK);
    do_write(12'h300, ONES);
    do_write(12'h100, 64'h0);
    chk("R4", 12'h300, ~MASK);
    chk("R5", 12'h100, 64'h0);
    do_write(12'h300, 64'h0000_0000_0000_1888);
    chk("R5", 12'h100, 64'h0);
    do_write(12'h300, 64'h0000_0001_0004_0022);
    chk("R5", 12'h100, 64'h0000_0001_0004_0022);

    // R8: unmapped addresses
    do_write(12'h7C0, ONES);
    chk("R8", 12'h7C0, 64'h0);
    chk("R8", 12'h344, 64'h0);
    chk("R8", 12'h340, 64'hA5A5_A5A5_A5A5_A5A5);
    chk("R8", 12'h341, 64'h1234_5678_9ABC_DEF0);

    // R9: old value visible until the edge, no change while idle
    @(negedge clk);
    addr  = 12'h340;
    wdata = 64'h1111_2222_3333_4444;
    wr_en = 1'b1;
    #1;
    compare("R9", 12'h340, 64'hA5A5_A5A5_A5A5_A5A5);
    @(negedge clk);
    wr_en = 1'b0;
    wdata = 64'h5555_6666_7777_8888;
    #1;
    compare("R9", 12'h340, 64'h1111_2222_3333_4444);
    repeat (3) @(posedge clk);
    chk("R9", 12'h340, 64'h1111_2222_3333_4444);

    // R1: asynchronous clear in mid-run
    @(negedge clk);
    addr  = 12'h340;
    rst_n = 1'b0;
    #1;
    compare("R1", 12'h340, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    chk("R1", 12'h305, 64'h0);
    chk("R1", 12'h102, 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule